// File: doc/BRIEF.md
# Half-Pel Bilinear Interpolator

This block turns a rectangular patch of 8-bit reference pixels into a grid with twice the resolution in each direction. Motion estimation and motion compensation then use that grid at half-pixel positions. Each source position produces four output samples:

- the source pixel itself;
- the average with its right neighbour;
- the average with its lower neighbour;
- the four-pixel average with the diagonal neighbour.

Every average rounds by adding a constant and then shifting right.

The patch size is given on two configuration inputs and captured by a start pulse. Source pixels then arrive as a raster-ordered valid/ready stream. The block keeps one line of pixels in registers and emits the doubled grid as a raster-ordered valid/ready stream. A 17x17 luminance patch yields 34x34 samples and a 9x9 chrominance patch yields 18x18 samples. Along the right and bottom edges the missing neighbours are replaced by the nearest existing pixel. This keeps the output exactly twice the input size.

Top module: `halfpel_interp`

## Requirements
- R1: An output at an even row and even column of the doubled grid equals source pixel A at (column/2, row/2) unchanged.
- R2: An output at an even row and odd column equals (A + B + 1) >> 1, where B is the pixel to the right of A.
- R3: An output at an odd row and even column equals (A + C + 1) >> 1, where C is the pixel below A.
- R4: An output at an odd row and odd column equals (A + B + C + D + 2) >> 2, where D is the pixel below B.
- R5: Where B, C or D would fall outside the patch, the pixel with the column and row clamped to the last valid index is used instead, so the last output column and row are defined.
- R6: For a W x H patch the block emits exactly 4*W*H samples in raster order over a 2W x 2H grid, then returns to idle with in_ready and out_valid both low.
- R7: While out_valid is high and out_ready is low, out_valid and out_pix hold. The block never raises in_ready and out_valid in the same cycle, and any pattern of stalls on either side gives the same output sequence.
- R8: start is honoured only when idle and only if 1 <= cfg_w <= MAX_W and 1 <= cfg_h <= MAX_H. The sizes are captured at that start. Any later start or change of cfg_w or cfg_h during a run has no effect.
- R9: After reset, in_ready and out_valid are low.
- R10: Any size from 1x1 up to MAX_W x MAX_H is supported, including 17x17 giving 34x34 and 9x9 giving 18x18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a patch, sampled only when idle |
| cfg_w | input | $clog2(MAX_W+1) | Patch width in source pixels |
| cfg_h | input | $clog2(MAX_H+1) | Patch height in source pixels |
| in_valid | input | 1 | Source pixel present |
| in_ready | output | 1 | Block accepts a source pixel this cycle |
| in_pix | input | PW | Source pixel, raster order |
| out_valid | output | 1 | Interpolated sample present |
| out_ready | input | 1 | Consumer accepts the sample |
| out_pix | output | PW | Interpolated sample, raster order over the doubled grid |

## Verification
The hardest case to reach is an odd output row. There the single line register is being overwritten by the next source row while diagonal samples still need the old values, and the input stream and the output stream take turns in a fine-grained way. The stimulus drives that case with random gaps on in_valid and random stalls on out_ready across several patch shapes, including 1-wide, 1-tall and full 17x17 patches. The sliding window must then survive every possible interleaving of accepted pixels and stalled samples. Checkerboard patches of 0 and 255 exercise the rounding at half values, and a start pulse injected mid-run checks that the captured size is kept.

// File: rtl/halfpel_interp.sv
module halfpel_interp #(
  parameter int MAX_W = 17,
  parameter int MAX_H = 17,
  parameter int PW    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [$clog2(MAX_W+1)-1:0] cfg_w,
  input  logic [$clog2(MAX_H+1)-1:0] cfg_h,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [PW-1:0]              in_pix,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [PW-1:0]              out_pix
);
  localparam int WW  = $clog2(MAX_W+1);
  localparam int HW  = $clog2(MAX_H+1);
  localparam int OCW = $clog2(2*MAX_W+1);
  localparam int ORW = $clog2(2*MAX_H+1);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_EVEN, S_ODD} state_t;

  state_t          st;
  logic [PW-1:0]   line [MAX_W];
  logic [WW-1:0]   w_q, ic;
  logic [HW-1:0]   h_q;
  logic [OCW-1:0]  oc;
  logic [ORW-1:0]  orow;
  logic [PW-1:0]   oa, ob, na, nb;

  function automatic logic [PW-1:0] avg2(input logic [PW-1:0] x, input logic [PW-1:0] y);
    logic [PW:0] s;
    s = {1'b0, x} + {1'b0, y} + (PW+1)'(1);
    return s[PW:1];
  endfunction

  function automatic logic [PW-1:0] avg4(input logic [PW-1:0] x, input logic [PW-1:0] y,
                                         input logic [PW-1:0] u, input logic [PW-1:0] v);
    logic [PW+1:0] s;
    s = {2'b0, x} + {2'b0, y} + {2'b0, u} + {2'b0, v} + (PW+2)'(2);
    return s[PW+1:2];
  endfunction

  logic [OCW-1:0] w2, owed;
  logic [ORW-1:0] h2;
  logic [WW-1:0]  col, nxt;
  logic [PW-1:0]  ea, eb;
  logic           cfg_ok, last_col;

  assign w2       = OCW'({w_q, 1'b0});
  assign h2       = ORW'({h_q, 1'b0});
  assign owed     = (ic == '0) ? '0 : (ic == w_q) ? w2 : OCW'({ic, 1'b0}) - OCW'(1);
  assign col      = WW'(oc >> 1);
  assign nxt      = (col + WW'(1) < w_q) ? col + WW'(1) : col;
  assign ea       = line[col];
  assign eb       = line[nxt];
  assign last_col = (oc == w2 - OCW'(1));
  assign cfg_ok   = (cfg_w != '0) && (int'(cfg_w) <= MAX_W) && (cfg_h != '0) && (int'(cfg_h) <= MAX_H);

  assign in_ready  = (st == S_LOAD) || (st == S_ODD && ic < w_q && oc == owed);
  assign out_valid = (st == S_EVEN) || (st == S_ODD && oc < owed);

  always_comb begin
    if (st == S_EVEN)
      out_pix = oc[0] ? avg2(ea, eb) : ea;
    else if (!oc[0] || last_col)
      out_pix = avg2(ob, nb);
    else
      out_pix = avg4(oa, ob, na, nb);
  end

  always_ff @(posedge clk)
    if (in_valid && in_ready) line[ic] <= in_pix;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      w_q  <= '0;
      h_q  <= '0;
      ic   <= '0;
      oc   <= '0;
      orow <= '0;
      oa   <= '0;
      ob   <= '0;
      na   <= '0;
      nb   <= '0;
    end else begin
      case (st)
        S_IDLE: if (start && cfg_ok) begin
          w_q  <= cfg_w;
          h_q  <= cfg_h;
          ic   <= '0;
          oc   <= '0;
          orow <= '0;
          st   <= S_LOAD;
        end
        S_LOAD: if (in_valid) begin
          if (ic == w_q - WW'(1)) begin
            ic <= '0;
            st <= S_EVEN;
          end else ic <= ic + WW'(1);
        end
        S_EVEN: if (out_ready) begin
          if (last_col) begin
            oc   <= '0;
            orow <= orow + ORW'(1);
            ic   <= '0;
            if (orow == h2 - ORW'(1))      st <= S_IDLE;
            else if (orow != h2 - ORW'(2)) st <= S_ODD;
          end else oc <= oc + OCW'(1);
        end
        S_ODD: begin
          if (in_valid && in_ready) begin
            ic <= ic + WW'(1);
            oa <= ob;
            na <= nb;
            ob <= line[ic];
            nb <= in_pix;
          end
          if (out_valid && out_ready) begin
            if (last_col) begin
              oc   <= '0;
              orow <= orow + ORW'(1);
              st   <= S_EVEN;
            end else oc <= oc + OCW'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r7_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pix));

  a_r7_one_side: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  a_r8_size_kept: assert property (@(posedge clk) disable iff (!rst_n)
    st != S_IDLE |=> $stable(w_q) && $stable(h_q));

  a_r6_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_EVEN && out_ready && last_col && orow == h2 - ORW'(1) |=> !out_valid && !in_ready);

  a_r4_diag_bound: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_ODD && out_valid && oc[0] && !last_col |->
      (out_pix <= oa || out_pix <= ob || out_pix <= na || out_pix <= nb) &&
      (out_pix >= oa || out_pix >= ob || out_pix >= na || out_pix >= nb));
endmodule

// File: tb/test_halfpel_interp.sv
module test_halfpel_interp;
  localparam int MAX_W = 17;
  localparam int MAX_H = 17;

  logic       clk = 0, rst_n = 0, start = 0;
  logic [4:0] cfg_w = '0, cfg_h = '0;
  logic       in_valid = 0, in_ready, out_valid, out_ready = 0;
  logic [7:0] in_pix = '0, out_pix;

  halfpel_interp #(.MAX_W(MAX_W), .MAX_H(MAX_H), .PW(8)) i_halfpel_interp (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_w(cfg_w), .cfg_h(cfg_h),
    .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix));

  always #10 clk = ~clk;

  int checks = 0, errors = 0, got = 0;
  bit rnd_ready = 0, rnd_gap = 0, hold_chk = 0;
  logic [7:0] hold_val;
  int exp_q[$];
  string tag_q[$];
  logic [7:0] img [MAX_H][MAX_W];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int px(input int x, input int y, input int w, input int h);
    return int'(img[(y < h) ? y : h-1][(x < w) ? x : w-1]);
  endfunction

  always @(negedge clk) begin
    out_ready = rnd_ready ? ($urandom % 4 != 0) : 1'b1;
    if (hold_chk) chk(out_valid && out_pix == hold_val, "R7 hold", int'(out_pix), int'(hold_val));
    hold_chk = out_valid && !out_ready;
    hold_val = out_pix;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) chk(0, "R6 extra sample", int'(out_pix), -1);
      else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(int'(out_pix) == e, t, int'(out_pix), e);
      end
      got++;
    end
  end

  task automatic send_pix(input logic [7:0] p);
    if (rnd_gap) repeat ($urandom % 3) @(negedge clk);
    in_valid = 1;
    in_pix = p;
    while (1) begin
      if (in_ready) begin
        @(posedge clk);
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    in_valid = 0;
  endtask

  task automatic run_frame(input int w, input int h, input int mode, input bit poke);
    for (int y = 0; y < h; y++)
      for (int x = 0; x < w; x++)
        case (mode)
          0: img[y][x] = 8'($urandom);
          1: img[y][x] = 8'd255;
          2: img[y][x] = ((x + y) % 2 == 1) ? 8'd255 : 8'd0;
          default: img[y][x] = 8'(x * 15 + y);
        endcase
    for (int oy = 0; oy < 2*h; oy++)
      for (int ox = 0; ox < 2*w; ox++) begin
        int a, b, c, d, e;
        string t;
        a = px(ox/2, oy/2, w, h);
        b = px(ox/2+1, oy/2, w, h);
        c = px(ox/2, oy/2+1, w, h);
        d = px(ox/2+1, oy/2+1, w, h);
        if (oy % 2 == 0 && ox % 2 == 0) begin e = a; t = "R1 integer"; end
        else if (oy % 2 == 0) begin e = (a + b + 1) >> 1; t = "R2 horizontal"; end
        else if (ox % 2 == 0) begin e = (a + c + 1) >> 1; t = "R3 vertical"; end
        else begin e = (a + b + c + d + 2) >> 2; t = "R4 diagonal"; end
        if ((ox % 2 == 1 && ox/2 == w-1) || (oy % 2 == 1 && oy/2 == h-1)) t = {t, " R5 edge"};
        exp_q.push_back(e);
        tag_q.push_back(t);
      end
    got = 0;
    cfg_w = 5'(w);
    cfg_h = 5'(h);
    start = 1;
    @(negedge clk);
    start = 0;
    for (int y = 0; y < h; y++)
      for (int x = 0; x < w; x++) begin
        send_pix(img[y][x]);
        if (poke && y == 0 && x == 1) begin
          cfg_w = 5'd2;
          cfg_h = 5'd2;
          start = 1;
          @(negedge clk);
          start = 0;
        end
      end
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(!in_ready && !out_valid, "R6 idle after frame", int'({in_ready, out_valid}), 0);
    chk(got == 4*w*h, poke ? "R8 size kept / R10 count" : "R10 sample count", got, 4*w*h);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!in_ready && !out_valid, "R9 reset state", int'({in_ready, out_valid}), 0);
    rst_n = 1;
    @(negedge clk);
    chk(!in_ready && !out_valid, "R9 idle after reset", int'({in_ready, out_valid}), 0);

    cfg_w = 5'd0; cfg_h = 5'd3; start = 1;
    @(negedge clk); start = 0;
    repeat (2) @(negedge clk);
    chk(!in_ready && !out_valid, "R8 zero width ignored", int'({in_ready, out_valid}), 0);
    cfg_w = 5'd18; cfg_h = 5'd3; start = 1;
    @(negedge clk); start = 0;
    repeat (2) @(negedge clk);
    chk(!in_ready && !out_valid, "R8 oversize ignored", int'({in_ready, out_valid}), 0);

    run_frame(4, 3, 3, 0);
    run_frame(2, 2, 2, 0);
    run_frame(1, 1, 0, 0);
    rnd_ready = 1;
    rnd_gap = 1;
    run_frame(5, 4, 0, 1);
    run_frame(1, 5, 0, 0);
    run_frame(6, 1, 0, 0);
    run_frame(3, 3, 1, 0);
    run_frame(6, 6, 2, 0);
    run_frame(9, 9, 0, 0);
    run_frame(17, 17, 0, 0);
    rnd_ready = 0;
    rnd_gap = 0;
    run_frame(17, 17, 3, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule